// File: doc/BRIEF.md
# Interrupt Mask and Level Controller

This block keeps the per-source mask of a 64-input interrupt controller together with a pair of three-bit level masks used for nested service. Raw request lines enter, and the block presents them again with every masked source forced low. Software reaches the state through a small word-wide register port. A separate set-mask port lets a service routine mask one source, or every source, in a single write with no read-modify-write of the mask.

When automatic level masking is enabled, each acknowledge strobe loads the acknowledged level into the current level mask. On the same clock edge, the value it held before moves into the saved level mask. Software can later write the saved value back when the routine returns. The block also drives a bus-priority-elevate output. That output is high while the level offered to the core has its elevation enable set, and it is forced low in round-robin arbitration mode. Priority encoding and vector generation are done elsewhere.

Top module: `irq_mask_level_ctrl`

## Requirements
- R1: After reset the mask register is all ones, so `irq_o` is zero for any `irq_i`. The configuration, current level and saved level registers reset to zero.
- R2: `irq_o[i]` equals `irq_i[i]` AND NOT mask bit i. This path is combinational.
- R3: Register address 0 reads and writes mask bits 31:0, and address 1 reads and writes mask bits 63:32. A write takes effect on the next clock edge.
- R4: A set-mask code has bit 7 reserved and ignored, bit 6 as the set-all flag and bits 5:0 as an index. The code arrives either through `set_we_i`/`set_data_i` or through a register write to address 2 (`reg_wdata_i[7:0]`). With bit 6 clear it sets only the mask bit named by the index. Every other mask bit keeps its value.
- R5: A set-mask code with bit 6 set sets all 64 mask bits, whatever the index holds.
- R6: Reading address 2 returns zero.
- R7: When a direct mask write and a set-mask code land in the same cycle, the direct write is applied first and the set bits are ORed on top.
- R8: Address 3 is the configuration register. Bit 0 is the auto-mask enable, and bit n (n = 1..7) is the elevation enable for level n. Bits 31:8 read as zero and ignore writes.
- R9: While auto-mask is enabled, `ack_i` loads `ack_lvl_i` into the current level and, on the same edge, the old current level into the saved level. The acknowledge wins over a software write to either level register in that cycle.
- R10: While auto-mask is disabled, `ack_i` leaves both level registers unchanged.
- R11: Address 4 (current level) and address 5 (saved level) read and write bits 2:0, and their upper bits read as zero. Unused addresses 6 and 7 read as zero.
- R12: `elevate_o` is combinationally high exactly when `pend_lvl_i` is nonzero and the elevation enable for that level is set.
- R13: `elevate_o` is low whenever `rr_mode_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for both read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| set_we_i | input | 1 | Set-mask port strobe |
| set_data_i | input | 8 | Set-mask code |
| irq_i | input | 64 | Raw interrupt requests |
| irq_o | output | 64 | Masked interrupt requests |
| ack_i | input | 1 | Acknowledge strobe |
| ack_lvl_i | input | 3 | Level being acknowledged (1..7) |
| pend_lvl_i | input | 3 | Highest pending level offered to the core (0 = none) |
| rr_mode_i | input | 1 | Round-robin arbitration mode |
| elevate_o | output | 1 | Bus-priority elevate request |

## Verification
The bench drives the set-mask code with the reserved bit 7 set. A decoder that read that bit would mask a source 128 positions away or the wrong word. It drives set-all with a nonzero index, which catches a design that sets only the indexed bit. It issues a direct word write and a set code in the same cycle, where the wrong order would lose either the written word or the set bit. It also acknowledges while software writes the current level, and acknowledges with auto-mask disabled. A design that swapped the save and load order would store the new level in the saved register, and one that ignored the enable would clobber a level software still needs. Random phases hit pending level 0 and round-robin mode, where an elevate that tracked the enables alone would stay high.

// File: rtl/irq_mlc_pkg.sv
package irq_mlc_pkg;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned NUM_LVL = 7;
  localparam int unsigned CFG_W   = NUM_LVL + 1;

  typedef struct packed {
    logic [NUM_LVL:1] elev_en;
    logic             auto_en;
  } cfg_t;
endpackage

// File: rtl/irq_set_decode.sv
module irq_set_decode #(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic               vld_i,
  input  logic [IDX_W:0]     code_i,
  output logic [NUM_IRQ-1:0] vec_o
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    assign vec_o[i] = vld_i && (code_i[IDX_W] || (code_i[IDX_W-1:0] == IDX_W'(i)));
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned NWORD  = NUM_IRQ / DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NWORD-1:0]   word_we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_IRQ-1:0] set_vec_i,
  output logic [NUM_IRQ-1:0] mask_o
);
  logic [NUM_IRQ-1:0] mask_q, mask_d;

  // direct word write first, indexed sets ORed on top
  always_comb begin
    mask_d = mask_q;
    for (int w = 0; w < int'(NWORD); w++) begin
      if (word_we_i[w]) mask_d[w*DATA_W +: DATA_W] = wdata_i;
    end
    mask_d = mask_d | set_vec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/lvl_mask_pair.sv
module lvl_mask_pair #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_en_i,
  input  logic             ack_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  input  logic             cur_we_i,
  input  logic             sav_we_i,
  input  logic [LVL_W-1:0] wdata_i,
  output logic [LVL_W-1:0] cur_o,
  output logic [LVL_W-1:0] sav_o
);
  logic [LVL_W-1:0] cur_q, sav_q;
  logic             auto_ld;

  assign auto_ld = ack_i && auto_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      sav_q <= '0;
    end else if (auto_ld) begin
      cur_q <= ack_lvl_i;
      sav_q <= cur_q;
    end else begin
      if (cur_we_i) cur_q <= wdata_i;
      if (sav_we_i) sav_q <= wdata_i;
    end
  end

  assign cur_o = cur_q;
  assign sav_o = sav_q;
endmodule

// File: rtl/prio_elevate.sv
module prio_elevate #(
  parameter int unsigned NUM_LVL = 7,
  parameter int unsigned LVL_W   = 3
) (
  input  logic [NUM_LVL:1] en_i,
  input  logic [LVL_W-1:0] pend_lvl_i,
  input  logic             rr_mode_i,
  output logic             elevate_o
);
  logic [NUM_LVL:1] hit;

  for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
    assign hit[l] = en_i[l] && (pend_lvl_i == LVL_W'(l));
  end

  assign elevate_o = !rr_mode_i && (|hit);
endmodule

// File: rtl/irq_mask_level_ctrl.sv
module irq_mask_level_ctrl
  import irq_mlc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ),
  localparam int unsigned SET_W  = IDX_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               set_we_i,
  input  logic [SET_W-1:0]   set_data_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [NUM_IRQ-1:0] irq_o,
  input  logic               ack_i,
  input  logic [LVL_W-1:0]   ack_lvl_i,
  input  logic [LVL_W-1:0]   pend_lvl_i,
  input  logic               rr_mode_i,
  output logic               elevate_o
);
  localparam int unsigned NWORD = NUM_IRQ / DATA_W;
  localparam logic [ADDR_W-1:0] ADR_SET = ADDR_W'(NWORD);
  localparam logic [ADDR_W-1:0] ADR_CFG = ADDR_W'(NWORD + 1);
  localparam logic [ADDR_W-1:0] ADR_CUR = ADDR_W'(NWORD + 2);
  localparam logic [ADDR_W-1:0] ADR_SAV = ADDR_W'(NWORD + 3);
  localparam int unsigned NSRC = 2;

  logic [NWORD-1:0]   word_we;
  logic [NUM_IRQ-1:0] mask;
  logic [NUM_IRQ-1:0] set_vec [NSRC];
  logic [NSRC-1:0]    src_vld;
  logic [IDX_W:0]     src_code [NSRC];
  cfg_t               cfg_q;
  logic [LVL_W-1:0]   cur_lvl, sav_lvl;
  logic               unused_rsvd;

  assign unused_rsvd = set_data_i[SET_W-1];

  for (genvar w = 0; w < NWORD; w++) begin : g_wwe
    assign word_we[w] = reg_we_i && (reg_addr_i == ADDR_W'(w));
  end

  // source 0: dedicated port, source 1: register write to the set address
  assign src_vld[0]  = set_we_i;
  assign src_code[0] = set_data_i[IDX_W:0];
  assign src_vld[1]  = reg_we_i && (reg_addr_i == ADR_SET);
  assign src_code[1] = reg_wdata_i[IDX_W:0];

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_set_decode #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_dec (
      .vld_i (src_vld[s]),
      .code_i(src_code[s]),
      .vec_o (set_vec[s])
    );
  end

  irq_mask_bank #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .word_we_i(word_we),
    .wdata_i  (reg_wdata_i),
    .set_vec_i(set_vec[0] | set_vec[1]),
    .mask_o   (mask)
  );

  assign irq_o = irq_i & ~mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cfg_q <= '0;
    else if (reg_we_i && reg_addr_i == ADR_CFG)   cfg_q <= cfg_t'(reg_wdata_i[CFG_W-1:0]);
  end

  lvl_mask_pair #(.LVL_W(LVL_W)) u_lvl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .auto_en_i(cfg_q.auto_en),
    .ack_i    (ack_i),
    .ack_lvl_i(ack_lvl_i),
    .cur_we_i (reg_we_i && reg_addr_i == ADR_CUR),
    .sav_we_i (reg_we_i && reg_addr_i == ADR_SAV),
    .wdata_i  (reg_wdata_i[LVL_W-1:0]),
    .cur_o    (cur_lvl),
    .sav_o    (sav_lvl)
  );

  prio_elevate #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_elev (
    .en_i      (cfg_q.elev_en),
    .pend_lvl_i(pend_lvl_i),
    .rr_mode_i (rr_mode_i),
    .elevate_o (elevate_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int w = 0; w < int'(NWORD); w++) begin
      if (reg_addr_i == ADDR_W'(w)) reg_rdata_o = mask[w*DATA_W +: DATA_W];
    end
    if (reg_addr_i == ADR_CFG) reg_rdata_o = DATA_W'(cfg_q);
    if (reg_addr_i == ADR_CUR) reg_rdata_o = DATA_W'(cur_lvl);
    if (reg_addr_i == ADR_SAV) reg_rdata_o = DATA_W'(sav_lvl);
  end
endmodule

// File: rtl/irq_mlc_checker.sv
module irq_mlc_checker
  import irq_mlc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ),
  localparam int unsigned SET_W  = IDX_W + 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic               set_we_i,
  input logic [SET_W-1:0]   set_data_i,
  input logic [NUM_IRQ-1:0] irq_o,
  input logic               ack_i,
  input logic [LVL_W-1:0]   ack_lvl_i,
  input logic [LVL_W-1:0]   pend_lvl_i,
  input logic               rr_mode_i,
  input logic               elevate_o,
  input logic               auto_en,
  input logic [LVL_W-1:0]   cur_lvl,
  input logic [LVL_W-1:0]   sav_lvl
);
  localparam int unsigned NWORD = NUM_IRQ / DATA_W;
  localparam logic [ADDR_W-1:0] ADR_SET = ADDR_W'(NWORD);
  localparam logic [ADDR_W-1:0] ADR_CFG = ADDR_W'(NWORD + 1);
  localparam logic [ADDR_W-1:0] ADR_CUR = ADDR_W'(NWORD + 2);
  localparam logic [ADDR_W-1:0] ADR_SAV = ADDR_W'(NWORD + 3);

  p_set_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !set_data_i[IDX_W]) |=> (irq_o[$past(set_data_i[IDX_W-1:0])] == 1'b0));

  p_set_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && set_data_i[IDX_W]) |=> (irq_o == '0));

  p_set_reads_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADR_SET) |-> (reg_rdata_o == '0));

  p_cfg_rsvd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADR_CFG) |-> (reg_rdata_o[DATA_W-1:CFG_W] == '0));

  p_auto_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && auto_en) |=> (cur_lvl == $past(ack_lvl_i) && sav_lvl == $past(cur_lvl)));

  p_no_auto_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !auto_en && !(reg_we_i && (reg_addr_i == ADR_CUR || reg_addr_i == ADR_SAV)))
    |=> ($stable(cur_lvl) && $stable(sav_lvl)));

  p_idle_no_elev_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_lvl_i == '0) |-> !elevate_o);

  p_rr_no_elev_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_mode_i |-> !elevate_o);
endmodule

bind irq_mask_level_ctrl irq_mlc_checker #(
  .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .set_we_i   (set_we_i),
  .set_data_i (set_data_i),
  .irq_o      (irq_o),
  .ack_i      (ack_i),
  .ack_lvl_i  (ack_lvl_i),
  .pend_lvl_i (pend_lvl_i),
  .rr_mode_i  (rr_mode_i),
  .elevate_o  (elevate_o),
  .auto_en    (cfg_q.auto_en),
  .cur_lvl    (cur_lvl),
  .sav_lvl    (sav_lvl)
);

// File: tb/tb_irq_mask_level_ctrl.sv
module tb_irq_mask_level_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        set_we_i = 1'b0;
  logic [7:0]  set_data_i = '0;
  logic [63:0] irq_i = '0;
  logic [63:0] irq_o;
  logic        ack_i = 1'b0;
  logic [2:0]  ack_lvl_i = '0;
  logic [2:0]  pend_lvl_i = '0;
  logic        rr_mode_i = 1'b0;
  logic        elevate_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic [63:0] m_mask = '1;
  logic [7:0]  m_cfg = '0;
  logic [2:0]  m_cur = '0, m_sav = '0;

  always #5 clk_i = ~clk_i;

  irq_mask_level_ctrl dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_mask[31:0];
      3'd1: return m_mask[63:32];
      3'd3: return {24'h0, m_cfg};
      3'd4: return {29'h0, m_cur};
      3'd5: return {29'h0, m_sav};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R3";
      3'd2: return "R6";
      3'd3: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic void apply_set(input logic [7:0] code);
    if (code[6]) m_mask = '1;
    else         m_mask[code[5:0]] = 1'b1;
  endfunction

  // compare all outputs against the model, then advance one clock
  task automatic cyc(input bit lit_en, input logic [31:0] lit, input string tag);
    logic exp_el;
    #2;
    exp_el = !rr_mode_i && (pend_lvl_i != 0) && m_cfg[pend_lvl_i];
    chk("R2", irq_o, irq_i & ~m_mask);
    chk(rd_tag(reg_addr_i), {32'h0, reg_rdata_o}, {32'h0, exp_rd(reg_addr_i)});
    chk(rr_mode_i ? "R13" : "R12", {63'h0, elevate_o}, {63'h0, exp_el});
    if (lit_en) chk(tag, {32'h0, reg_rdata_o}, {32'h0, lit});
    @(posedge clk_i);
    #1;
    if (ack_i && m_cfg[0]) begin
      m_sav = m_cur;
      m_cur = ack_lvl_i;
    end else if (reg_we_i) begin
      if (reg_addr_i == 3'd4) m_cur = reg_wdata_i[2:0];
      if (reg_addr_i == 3'd5) m_sav = reg_wdata_i[2:0];
    end
    if (reg_we_i) begin
      if (reg_addr_i == 3'd0) m_mask[31:0]  = reg_wdata_i;
      if (reg_addr_i == 3'd1) m_mask[63:32] = reg_wdata_i;
      if (reg_addr_i == 3'd2) apply_set(reg_wdata_i[7:0]);
      if (reg_addr_i == 3'd3) m_cfg = reg_wdata_i[7:0];
    end
    if (set_we_i) apply_set(set_data_i);
  endtask

  task automatic idle();
    reg_we_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    set_we_i = 0; set_data_i = 0; ack_i = 0; ack_lvl_i = 0;
    pend_lvl_i = 0; rr_mode_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] lit, input string tag);
    idle();
    reg_addr_i = a;
    cyc(1, lit, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    idle();
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    cyc(0, 0, "");
  endtask

  task automatic setp(input logic [7:0] code);
    idle();
    set_we_i = 1; set_data_i = code;
    cyc(0, 0, "");
  endtask

  task automatic elev(input logic [2:0] p, input logic rr, input logic exp, input string tag);
    idle();
    pend_lvl_i = p; rr_mode_i = rr;
    #2;
    chk(tag, {63'h0, elevate_o}, {63'h0, exp});
    cyc(0, 0, "");
  endtask

  initial begin
    idle();
    irq_i = '1;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1;
    // R1 reset state
    #2;
    chk("R1", irq_o, 64'h0);
    rd(3'd4, 0, "R1");
    rd(3'd5, 0, "R1");
    rd(3'd3, 0, "R1");
    // R3 direct words
    irq_i = 64'hA5A5_0F0F_1234_8001;
    wr(3'd0, 32'h0);
    rd(3'd0, 32'h0, "R3");
    wr(3'd1, 32'h0);
    rd(3'd1, 32'h0, "R3");
    #2 chk("R3", irq_o, irq_i);
    // R4 indexed set, reserved bit ignored
    setp(8'h25);
    rd(3'd1, 32'h20, "R4");
    setp(8'h83);
    rd(3'd0, 32'h8, "R4");
    idle();
    reg_we_i = 1; reg_addr_i = 3'd2; reg_wdata_i = 32'h0;
    cyc(1, 32'h0, "R6");
    rd(3'd0, 32'h9, "R4");
    rd(3'd1, 32'h20, "R4");
    // R5 set-all ignores index
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    setp(8'h45);
    rd(3'd0, 32'hFFFF_FFFF, "R5");
    rd(3'd1, 32'hFFFF_FFFF, "R5");
    #2 chk("R5", irq_o, 64'h0);
    // R7 direct write then OR
    idle();
    reg_we_i = 1; reg_addr_i = 3'd0; reg_wdata_i = 32'h1;
    set_we_i = 1; set_data_i = 8'h04;
    cyc(0, 0, "");
    rd(3'd0, 32'h11, "R7");
    rd(3'd2, 32'h0, "R6");
    // R8 config
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, 32'hFF, "R8");
    // R11 level registers
    wr(3'd4, 32'hFFFF_FFFD);
    rd(3'd4, 32'h5, "R11");
    rd(3'd6, 32'h0, "R11");
    // R9 auto-mask
    idle(); ack_i = 1; ack_lvl_i = 3'd3;
    cyc(0, 0, "");
    rd(3'd4, 32'h3, "R9");
    rd(3'd5, 32'h5, "R9");
    idle(); ack_i = 1; ack_lvl_i = 3'd6;
    reg_we_i = 1; reg_addr_i = 3'd4; reg_wdata_i = 32'h1;
    cyc(0, 0, "");
    rd(3'd4, 32'h6, "R9");
    rd(3'd5, 32'h3, "R9");
    // R10 auto disabled, level 4 elevation only
    wr(3'd3, 32'h10);
    idle(); ack_i = 1; ack_lvl_i = 3'd2;
    cyc(0, 0, "");
    rd(3'd4, 32'h6, "R10");
    rd(3'd5, 32'h3, "R10");
    // R12/R13 elevate
    elev(3'd4, 0, 1, "R12");
    elev(3'd3, 0, 0, "R12");
    elev(3'd0, 0, 0, "R12");
    elev(3'd4, 1, 0, "R13");
    // random phase compared against the model every clock
    for (int i = 0; i < 600; i++) begin
      reg_we_i    = ($urandom % 4) == 0;
      reg_addr_i  = 3'($urandom % 8);
      reg_wdata_i = $urandom;
      set_we_i    = ($urandom % 5) == 0;
      set_data_i  = 8'($urandom);
      ack_i       = ($urandom % 4) == 0;
      ack_lvl_i   = 3'($urandom);
      pend_lvl_i  = 3'($urandom);
      rr_mode_i   = ($urandom % 8) == 0;
      irq_i       = {$urandom, $urandom};
      if ((i % 50) == 0) begin
        reg_we_i = 1; reg_addr_i = 3'($urandom % 2); reg_wdata_i = 32'h0;
      end
      cyc(0, 0, "");
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule